// File: doc/BRIEF.md
# Period-Descriptor Playback Sequencer

This block is the fetch engine for one playback channel. It reads a table of period descriptors from memory. Each descriptor is two 32-bit words: the byte address of one period's samples, then that period's length in bytes held in bits [31:16]. For the current period the engine reads 32-bit stereo sample words in order from consecutive addresses. It places them in a small output FIFO. When a period ends it moves to the next descriptor and raises a sticky interrupt. After the last descriptor it returns to the first. Software sets the table base, the table size and the channel start bit through a small register port. It can read back the descriptor pointer, the position within the period and the FIFO fill.

Memory accesses go through a single-outstanding read port. A request is held until its response arrives. Before the first sample of each period is read, the engine fetches the following descriptor. When the last sample of a period returns, the engine switches to the next period at once, with no refetch.

Top module: `pdma_seq`

## Requirements
- R1: After reset every readable register (addresses 0 to 6) reads zero, `irq` is low, `mem_req` is low and `smp_valid` is low.
- R2: Setting bit CHAN of the control register (address 5) starts the engine. The engine reads the table base (address 0), then table base + 4. The first word is the period address. Bits [31:16] of the second word are the period length in bytes.
- R3: Sample words are read from period address + 0, +4, +8, … and leave `smp_data` in that order, each word exactly once.
- R4: After the number of bytes given by its descriptor, a period ends and descriptor n+1 is used, fetched from table base + 8·(n+1). Lengths may differ between descriptors.
- R5: The table size register (address 1) holds the table length in bytes in bits [31:16]. When the next offset would reach that size, descriptor 0 follows and playback continues with no gap.
- R6: Each completed period sets bit CHAN of the interrupt status register (address 6) and the `irq` output. The bit stays set until a write with bit CHAN set clears it. A write with that bit at 0 has no effect.
- R7: The descriptor pointer register (address 2, bits [15:0]) shows the byte offset of the current descriptor. It advances the cycle after a period's last sample is returned.
- R8: Samples are requested only while the FIFO (depth FIFO_DEPTH) has a free slot. With the output stalled, the FIFO status register (address 4) bits [15:0] reach FIFO_DEPTH and `mem_req` stays low.
- R9: Clearing the start bit lets any outstanding read finish, then the engine idles and issues no further requests.
- R10: The period pointer register (address 3, bits [15:0]) gives the bytes of the current period already returned from memory.
- R11: A raised `mem_req` stays high, with `mem_addr` unchanged, until the cycle in which `mem_rvalid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Sticky period-complete interrupt |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | AW | Byte address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| smp_valid | output | 1 | Output sample available |
| smp_ready | input | 1 | Sink accepts sample |
| smp_data | output | 32 | Output stereo sample word |

## Verification
The bench walks tables of one, two, three and eight descriptors. Some have per-descriptor length variation and a stalling sink. A design that used one fixed length, skipped the wrap or refetched from the wrong offset would produce a wrong sample stream. With the sink stalled, the bench checks that the FIFO fills to exactly its depth and that requests then stop. An engine that ignored the fill level would overrun. The bench checks the pointer readback after two periods and after a wrap, which exposes a late or missing switch-over. It also checks that a zero write leaves the interrupt set, that a one write clears it, and that no read follows a stop.

// File: rtl/pdma_pkg.sv
// Shared definitions for the period-descriptor playback sequencer.
package pdma_pkg;
    localparam int LEN_W      = 16;   // width of all byte-length fields
    localparam int DESC_BYTES = 8;    // descriptor stride in the table
    localparam int WORD_BYTES = 4;    // one stereo sample word

    // register addresses
    localparam logic [2:0] RA_LBASE = 3'd0;
    localparam logic [2:0] RA_LSIZE = 3'd1;
    localparam logic [2:0] RA_LPTR  = 3'd2;
    localparam logic [2:0] RA_PPTR  = 3'd3;
    localparam logic [2:0] RA_FSTAT = 3'd4;
    localparam logic [2:0] RA_CTRL  = 3'd5;
    localparam logic [2:0] RA_IRQ   = 3'd6;

    // kind of the outstanding memory read
    typedef enum logic [2:0] {
        OP_CUR_ADDR,
        OP_CUR_LEN,
        OP_NXT_ADDR,
        OP_NXT_LEN,
        OP_SAMPLE
    } mem_op_e;
endpackage

// File: rtl/pdma_fifo.sv
// Sample FIFO. Assumes DEPTH is a power of two and at least 2.
// The writer must only push while room_o is high; the read side is a
// valid/ready handshake with the head word presented combinationally.
module pdma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [W-1:0]                 din_i,
    output logic                         room_o,
    output logic                         valid_o,
    input  logic                         ready_i,
    output logic [W-1:0]                 dout_o,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic [$clog2(DEPTH)-1:0]     rd_idx_o
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  store_q [DEPTH];
    logic [IW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          pop;

    assign pop      = valid_o && ready_i;
    assign valid_o  = (cnt_q != '0);
    assign room_o   = (cnt_q < CW'(DEPTH));
    assign dout_o   = store_q[rd_q];
    assign cnt_o    = cnt_q;
    assign rd_idx_o = rd_q;

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push_i) store_q[wr_q] <= din_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= wr_q + 1'b1;
            if (pop)    rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CW'(DEPTH)));
    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/pdma_engine.sv
// Descriptor walker and sample fetcher. Keeps one memory read outstanding;
// the request is held until mem_rvalid_i. Assumes descriptor lengths are
// non-zero multiples of 4 and the table size a non-zero multiple of 8.
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [AW-1:0]    base_i,
    input  logic [LEN_W-1:0] lsize_i,
    input  logic             room_i,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_rvalid_i,
    input  logic [31:0]      mem_rdata_i,
    output logic             push_o,
    output logic [31:0]      push_data_o,
    output logic             done_o,
    output logic [LEN_W-1:0] list_ptr_o,
    output logic [LEN_W-1:0] per_ptr_o
);
    localparam int XW = LEN_W + 1;

    logic             active_q, pend_q, nxt_ok_q;
    mem_op_e          op_q;
    logic [AW-1:0]    addr_q, cur_addr_q, nxt_addr_q;
    logic [LEN_W-1:0] cur_len_q, nxt_len_q, ent_q, pos_q, nxt_off;
    logic             resp, last;

    assign resp        = pend_q && mem_rvalid_i;
    assign nxt_off     = ((XW'(ent_q) + XW'(DESC_BYTES)) >= XW'(lsize_i)) ? '0
                         : ent_q + LEN_W'(DESC_BYTES);
    assign last        = (XW'(pos_q) + XW'(WORD_BYTES)) >= XW'(cur_len_q);
    assign push_o      = resp && (op_q == OP_SAMPLE);
    assign push_data_o = mem_rdata_i;
    assign done_o      = push_o && last;
    assign mem_req_o   = pend_q;
    assign mem_addr_o  = addr_q;
    assign list_ptr_o  = ent_q;
    assign per_ptr_o   = pos_q;

    // Sequencer: start, response handling, next-read selection and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            pend_q     <= 1'b0;
            nxt_ok_q   <= 1'b0;
            op_q       <= OP_CUR_ADDR;
            addr_q     <= '0;
            cur_addr_q <= '0;
            nxt_addr_q <= '0;
            cur_len_q  <= '0;
            nxt_len_q  <= '0;
            ent_q      <= '0;
            pos_q      <= '0;
        end else if (!active_q) begin
            if (run_i) begin
                active_q <= 1'b1;
                pend_q   <= 1'b1;
                op_q     <= OP_CUR_ADDR;
                addr_q   <= base_i;
                ent_q    <= '0;
                pos_q    <= '0;
                nxt_ok_q <= 1'b0;
            end
        end else if (resp) begin
            pend_q <= 1'b0;
            unique case (op_q)
                OP_CUR_ADDR: begin
                    cur_addr_q <= mem_rdata_i;
                    pend_q     <= 1'b1;
                    op_q       <= OP_CUR_LEN;
                    addr_q     <= addr_q + AW'(WORD_BYTES);
                end
                OP_CUR_LEN: cur_len_q <= mem_rdata_i[31:16];
                OP_NXT_ADDR: begin
                    nxt_addr_q <= mem_rdata_i;
                    pend_q     <= 1'b1;
                    op_q       <= OP_NXT_LEN;
                    addr_q     <= addr_q + AW'(WORD_BYTES);
                end
                OP_NXT_LEN: begin
                    nxt_len_q <= mem_rdata_i[31:16];
                    nxt_ok_q  <= 1'b1;
                end
                OP_SAMPLE: begin
                    if (last) begin
                        pos_q      <= '0;
                        ent_q      <= nxt_off;
                        cur_addr_q <= nxt_addr_q;
                        cur_len_q  <= nxt_len_q;
                        nxt_ok_q   <= 1'b0;
                    end else begin
                        pos_q <= pos_q + LEN_W'(WORD_BYTES);
                    end
                end
                default: ;
            endcase
            if (!run_i) begin
                active_q <= 1'b0;
                pend_q   <= 1'b0;
            end
        end else if (!pend_q) begin
            if (!run_i) begin
                active_q <= 1'b0;
            end else if (!nxt_ok_q) begin
                pend_q <= 1'b1;
                op_q   <= OP_NXT_ADDR;
                addr_q <= base_i + AW'(nxt_off);
            end else if (room_i) begin
                pend_q <= 1'b1;
                op_q   <= OP_SAMPLE;
                addr_q <= cur_addr_q + AW'(pos_q);
            end
        end
    end

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
    p_quiet_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !mem_req_o) |=> !mem_req_o);
    p_period_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (per_ptr_o == '0));
    p_sample_needs_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_o) && op_q == OP_SAMPLE) |-> $past(room_i));
endmodule

// File: rtl/pdma_regs.sv
// Software register file: table base, table size, start bits, sticky
// write-one-to-clear interrupt status and read-back of engine state.
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NCH  = 4,
    parameter int CHAN = 0,
    parameter int CW   = 3,
    parameter int IW   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [2:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic [AW-1:0]    base_o,
    output logic [LEN_W-1:0] lsize_o,
    output logic             run_o,
    output logic             irq_o,
    input  logic             done_i,
    input  logic [LEN_W-1:0] list_ptr_i,
    input  logic [LEN_W-1:0] per_ptr_i,
    input  logic [CW-1:0]    fifo_cnt_i,
    input  logic [IW-1:0]    fifo_idx_i
);
    logic [AW-1:0]    base_q;
    logic [LEN_W-1:0] lsize_q;
    logic [NCH-1:0]   ctrl_q;
    logic             irq_q, clr;

    assign clr     = wr_i && (addr_i == RA_IRQ) && wdata_i[CHAN];
    assign base_o  = base_q;
    assign lsize_o = lsize_q;
    assign run_o   = ctrl_q[CHAN];
    assign irq_o   = irq_q;

    // Writable fields and the sticky interrupt (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            lsize_q <= '0;
            ctrl_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_i && addr_i == RA_LBASE) base_q  <= wdata_i[AW-1:0];
            if (wr_i && addr_i == RA_LSIZE) lsize_q <= wdata_i[31:16];
            if (wr_i && addr_i == RA_CTRL)  ctrl_q  <= wdata_i[NCH-1:0];
            if (done_i)   irq_q <= 1'b1;
            else if (clr) irq_q <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        unique case (addr_i)
            RA_LBASE: rdata_o = 32'(base_q);
            RA_LSIZE: rdata_o = {lsize_q, 16'h0000};
            RA_LPTR:  rdata_o = {16'h0000, list_ptr_i};
            RA_PPTR:  rdata_o = {16'h0000, per_ptr_i};
            RA_FSTAT: rdata_o = {16'(fifo_idx_i), 16'(fifo_cnt_i)};
            RA_CTRL:  rdata_o = 32'(ctrl_q);
            RA_IRQ:   rdata_o = 32'(irq_q) << CHAN;
            default:  rdata_o = '0;
        endcase
    end

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr) |=> irq_q);
    p_irq_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> irq_q);
endmodule

// File: rtl/pdma_seq.sv
// Top: one playback channel. Wires the register file, the descriptor
// walker and the sample FIFO. CHAN selects the start and interrupt bit.
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int NCH        = 4,
    parameter int CHAN       = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          smp_valid,
    input  logic          smp_ready,
    output logic [31:0]   smp_data
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam int IW = $clog2(FIFO_DEPTH);

    logic             run, room, push, done;
    logic [31:0]      push_data;
    logic [AW-1:0]    base;
    logic [LEN_W-1:0] lsize, list_ptr, per_ptr;
    logic [CW-1:0]    fcnt;
    logic [IW-1:0]    fidx;

    pdma_regs #(.AW(AW), .NCH(NCH), .CHAN(CHAN), .CW(CW), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .base_o(base),
        .lsize_o(lsize), .run_o(run), .irq_o(irq), .done_i(done),
        .list_ptr_i(list_ptr), .per_ptr_i(per_ptr), .fifo_cnt_i(fcnt),
        .fifo_idx_i(fidx)
    );

    pdma_engine #(.AW(AW)) u_engine (
        .clk(clk), .rst_n(rst_n), .run_i(run), .base_i(base),
        .lsize_i(lsize), .room_i(room), .mem_req_o(mem_req),
        .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata), .push_o(push), .push_data_o(push_data),
        .done_o(done), .list_ptr_o(list_ptr), .per_ptr_o(per_ptr)
    );

    pdma_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(push_data),
        .room_o(room), .valid_o(smp_valid), .ready_i(smp_ready),
        .dout_o(smp_data), .cnt_o(fcnt), .rd_idx_o(fidx)
    );
endmodule

// File: tb/pdma_seq_bench.sv
`timescale 1ns/1ps
module pdma_seq_bench;
    localparam int          DEPTH = 4;
    localparam int          CHAN  = 0;
    localparam logic [31:0] LB    = 32'h0000_0100;

    // vectors: [31:24] descriptors, [23:8] base period bytes,
    //          [1] alternate lengths, [0] stalling sink
    localparam logic [31:0] VEC [4] = '{
        32'h01_0004_00, 32'h03_0008_02, 32'h02_000C_03, 32'h08_0004_01
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, mem_rvalid = 1'b0, smp_ready = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, mem_addr, mem_rdata = '0, smp_data;
    logic        irq, mem_req, smp_valid;

    int checks = 0, fails = 0;
    int cfg_nent = 1, cfg_plen = 4;
    bit cfg_alt = 1'b0;
    int hold_viol = 0;

    always #2.5 clk = ~clk;

    pdma_seq #(.FIFO_DEPTH(DEPTH), .CHAN(CHAN)) u_pdma_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_data(smp_data)
    );

    function automatic int plen_of(int e);
        return cfg_plen + ((cfg_alt && (e % 2 == 1)) ? 4 : 0);
    endfunction
    function automatic logic [31:0] pbase(int e);
        return 32'h0001_0000 + 32'(e) * 32'h400;
    endfunction
    function automatic logic [31:0] mem_word(logic [31:0] a);
        int e;
        if (a >= LB && a < LB + 32'(cfg_nent * 8)) begin
            e = int'((a - LB) >> 3);
            return a[2] ? (32'(plen_of(e)) << 16) : pbase(e);
        end
        return a ^ 32'h5A00_0000;
    endfunction

    // memory model: answers a held request at the next falling edge
    always @(negedge clk) begin
        if (mem_rvalid) mem_rvalid = 1'b0;
        else if (mem_req) begin
            mem_rdata  = mem_word(mem_addr);
            mem_rvalid = 1'b1;
        end
    end

    // request-hold monitor for R11
    logic p_req = 1'b0, p_rv = 1'b0;
    logic [31:0] p_addr = '0;
    always @(posedge clk) begin
        if (rst_n && p_req && !p_rv && !(mem_req && mem_addr == p_addr))
            hold_viol++;
        p_req  = mem_req && rst_n;
        p_rv   = mem_rvalid;
        p_addr = mem_addr;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic stop_and_drain();
        wr(3'd5, 32'h0);
        repeat (6) @(negedge clk);
        smp_ready = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        smp_ready = 1'b0;
        wr(3'd6, 32'h1 << CHAN);
    endtask

    // collect n samples and compare with the expected address walk
    task automatic collect(int n, bit stall, output int errs);
        int e = 0, o = 0, got = 0, cyc = 0;
        logic [31:0] exp;
        errs = 0;
        while (got < n && cyc < 8000) begin
            @(negedge clk);
            smp_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (smp_valid && smp_ready) begin
                exp = (pbase(e) + 32'(o)) ^ 32'h5A00_0000;
                if (smp_data !== exp) begin
                    if (errs == 0)
                        $display("  sample %0d got %h want %h", got, smp_data, exp);
                    errs++;
                end
                got++;
                o += 4;
                if (o >= plen_of(e)) begin o = 0; e = (e + 1) % cfg_nent; end
            end
            cyc++;
        end
        if (got < n) errs += n - got;
        @(negedge clk);
        smp_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int errs, total, quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            chk(d == 0, "R1 register reset", d, 0);
        end
        chk(!irq && !mem_req && !smp_valid, "R1 outputs idle",
            {irq, mem_req, smp_valid}, 0);

        wr(3'd0, LB);

        // vector table: R3 order, R4 per-descriptor lengths, R5 wrap, R6 irq
        for (int v = 0; v < 4; v++) begin
            stop_and_drain();
            cfg_nent = int'(VEC[v][31:24]);
            cfg_plen = int'(VEC[v][23:8]);
            cfg_alt  = VEC[v][1];
            total = 0;
            for (int e = 0; e < cfg_nent; e++) total += plen_of(e) / 4;
            wr(3'd1, 32'(cfg_nent * 8) << 16);
            wr(3'd5, 32'h1 << CHAN);
            collect(2 * total + 3, VEC[v][0], errs);
            chk(errs == 0, "R3 R4 R5 sample stream", errs, 0);
            chk(irq == 1'b1, "R6 irq after periods", irq, 1);
        end

        // directed: first fetches, stalled fill, pointers
        stop_and_drain();
        cfg_nent = 3; cfg_plen = 8; cfg_alt = 0;
        wr(3'd1, 32'h0018_0000);
        wr(3'd5, 32'h1 << CHAN);
        @(negedge clk);
        chk(mem_req && mem_addr == LB, "R2 first descriptor word", mem_addr, LB);
        @(negedge clk);
        chk(mem_req && mem_addr == LB + 4, "R2 second descriptor word",
            mem_addr, LB + 4);
        repeat (80) @(negedge clk);
        rd(3'd4, d);
        chk(d[15:0] == 16'(DEPTH), "R8 fifo fills to depth", d[15:0], DEPTH);
        quiet = 0;
        repeat (12) begin @(negedge clk); if (mem_req) quiet++; end
        chk(quiet == 0, "R8 no request when full", quiet, 0);
        rd(3'd2, d);
        chk(d == 32'd16, "R7 descriptor pointer after two periods", d, 16);
        rd(3'd3, d);
        chk(d == 32'd0, "R10 period pointer at period start", d, 0);
        chk(irq == 1'b1, "R6 irq set", irq, 1);
        wr(3'd6, 32'h0);
        rd(3'd6, d);
        chk(d[CHAN] == 1'b1 && irq, "R6 zero write ignored", d, 32'h1 << CHAN);
        wr(3'd6, 32'h1 << CHAN);
        rd(3'd6, d);
        chk(d == 0 && !irq, "R6 write-one clears", d, 0);

        // directed: wrap of the pointer with two descriptors
        stop_and_drain();
        cfg_nent = 2; cfg_plen = 8; cfg_alt = 0;
        wr(3'd1, 32'h0010_0000);
        wr(3'd5, 32'h1 << CHAN);
        repeat (80) @(negedge clk);
        rd(3'd2, d);
        chk(d == 32'd0, "R5 pointer wrapped to descriptor 0", d, 0);
        @(negedge clk); smp_ready = 1'b1;
        @(negedge clk); smp_ready = 1'b0;
        repeat (20) @(negedge clk);
        rd(3'd3, d);
        chk(d == 32'd4, "R10 period pointer after one refill", d, 4);

        // directed: stop while streaming
        smp_ready = 1'b1;
        repeat (20) @(negedge clk);
        wr(3'd5, 32'h0);
        repeat (4) @(negedge clk);
        quiet = 0;
        repeat (30) begin @(negedge clk); if (mem_req) quiet++; end
        chk(quiet == 0, "R9 no requests after stop", quiet, 0);
        chk(!smp_valid, "R9 fifo drained and idle", smp_valid, 0);
        smp_ready = 1'b0;

        chk(hold_viol == 0, "R11 request held until response", hold_viol, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule